// File: doc/BRIEF.md
# Page-Mode DRAM Strobe Controller

This block sits between a simple synchronous request port and an asynchronous DRAM that takes its address over one multiplexed bus. A request carries a write flag, a 19-bit word address and 16 bits of write data. The controller splits the address into a 10-bit row and a 9-bit column. It opens the row by dropping the row strobe, then runs a column cycle by dropping the column strobe. For reads it returns the sampled word with a one-cycle valid pulse.

When a new request is waiting as soon as a column cycle ends, and it targets the open row, the row strobe stays low. Only another column cycle runs, so the row address is not sent again. A request to another row, a refresh, or a cycle with no request closes the row. Closing the row means a precharge before the next row is opened. Every pulse width and recovery gap is a parameter in clock cycles and is enforced with counters. A free-running interval timer requests a refresh, which the controller performs with the column strobe dropped before the row strobe. A pending refresh blocks new requests.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: At each row-strobe fall of a data access, `dram_addr` holds the row, which is request address bits 18:9. At each column-strobe fall, `dram_addr` holds the column, which is address bits 8:0, zero-extended to 10 bits. Accesses reach the memory in request order.
- R2: When requests to one row follow each other with no idle cycle, the row strobe stays low across them and falls once for the whole run, unless a refresh intervenes.
- R3: A request to a different row, a pending refresh, or a cycle in the open state with no request closes the row. The row strobe rises, and after an idle gap it is high.
- R4: Once it has fallen, the row strobe stays low for at least T_RAS cycles.
- R5: Between a rise and the next fall, the row strobe stays high for at least T_RP cycles.
- R6: Between a rise and the next fall, the column strobe stays high for at least T_CP cycles.
- R7: Write (early write): the write strobe is already low in the cycle before the column strobe falls. At that fall, the output enable is high, the data drivers are on (`dram_dq_oe`=1) and `dram_dq_out` equals the request data.
- R8: Read: the write strobe is high at the column strobe fall, and the output enable is low only while the column strobe is low and the write strobe is high. The word on `dram_dq_in` is sampled after T_ACC cycles of column strobe low. It is returned on `rd_data` with a one-cycle `rd_valid`, one pulse per read, in order.
- R9: Every REF_INT cycles a refresh becomes pending. The refresh drops the column strobe while the row strobe is high, with the write strobe high and `req_ready` low. It then drops the row strobe for T_RAS cycles.
- R10: After reset, all strobes are high (inactive), `dram_dq_oe`=0, `rd_valid`=0 and `req_ready`=1.
- R11: During a data access, the column strobe stays low for exactly T_CAS cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address, row in 18:9, column in 8:0 |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Request accepted on this edge when valid |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 16 | Read data |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data to memory |
| dram_dq_oe | output | 1 | Drive enable for data to memory |
| dram_dq_in | input | 16 | Data from memory |

## Verification
On every cycle, the in-RTL properties check the strobe pulse and recovery widths, the exact column-low width, the ordering of the write strobe before the column strobe, the exclusion of output enable from writes, and the write strobe state during refresh. Which address and data reach the memory in which order, and whether a run of same-row requests really shares one row opening, can be shown only by the bench's request sequences. The same holds for whether read words come back correctly and in order, and whether refresh occurs at all. For these, the bench uses a strobe-level memory model whose read data is a known function of row and column.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [3:0] {
    S_IDLE,   // row closed, precharge met
    S_RAS,    // row strobe low, row address held
    S_COL,    // column address set up, write strobe placed
    S_CAS,    // column strobe low
    S_CPRE,   // column precharge
    S_OPEN,   // row open, waiting for a page hit
    S_PRE,    // row precharge
    S_RFC,    // refresh: column strobe low first
    S_RFR     // refresh: row strobe low
  } fpm_state_e;
endpackage

// File: rtl/fpm_phase_timer.sv
module fpm_phase_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/fpm_age_counter.sv
module fpm_age_counter #(
  parameter int W    = 4,
  parameter int INIT = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic         active,
  output logic [W-1:0] age
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst)                        age <= W'(INIT);
    else if (restart)               age <= W'(1);
    else if (active && age != TOP)  age <= age + 1'b1;
  end
endmodule

// File: rtl/fpm_refresh_timer.sv
module fpm_refresh_timer #(
  parameter int INTERVAL = 780
) (
  input  logic clk,
  input  logic rst,
  input  logic ack,
  output logic pend
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick)     pend <= 1'b1;
      else if (ack) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_pkg::*;
#(
  parameter int ROW_W   = 10,
  parameter int COL_W   = 9,
  parameter int DATA_W  = 16,
  parameter int T_RCD   = 2,
  parameter int T_RAS   = 6,
  parameter int T_RP    = 3,
  parameter int T_CAS   = 3,
  parameter int T_CP    = 2,
  parameter int T_ACC   = 2,
  parameter int REF_INT = 780
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_valid,
  input  logic                         req_write,
  input  logic [ROW_W+COL_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]            req_wdata,
  output logic                         req_ready,
  output logic                         rd_valid,
  output logic [DATA_W-1:0]            rd_data,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic                         dram_ras_n,
  output logic                         dram_cas_n,
  output logic                         dram_we_n,
  output logic                         dram_oe_n,
  output logic [DATA_W-1:0]            dram_dq_out,
  output logic                         dram_dq_oe,
  input  logic [DATA_W-1:0]            dram_dq_in
);
  localparam int MA_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int TSUM = T_RCD + T_RAS + T_RP + T_CAS + T_CP;
  localparam int TW   = $clog2(TSUM + 1);
  localparam int AW   = $clog2(TSUM + T_ACC + 2) + 1;

  fpm_state_e state, n_state;

  logic [ROW_W-1:0]  row_q, n_row;
  logic [COL_W-1:0]  col_q, n_col;
  logic              wr_q, n_wr;
  logic [DATA_W-1:0] wdata_q, n_wdata;
  logic              n_ras_n, n_cas_n, n_we_n, n_oe_n, n_dq_oe, n_rd_valid;
  logic [MA_W-1:0]   n_addr;
  logic [DATA_W-1:0] n_dq_out, n_rd_data;

  logic              t_load, t_done;
  logic [TW-1:0]     t_val;
  logic              ras_restart, cas_restart, ref_ack, ref_pend;
  logic [AW-1:0]     ras_age, cas_age;
  logic              ras_ok, row_hit, accept;
  logic [ROW_W-1:0]  req_row;
  logic [COL_W-1:0]  req_col;

  assign req_row = req_addr[ROW_W+COL_W-1:COL_W];
  assign req_col = req_addr[COL_W-1:0];

  fpm_phase_timer #(.W(TW)) u_phase (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .done(t_done)
  );

  fpm_age_counter #(.W(AW), .INIT(0)) u_ras_age (
    .clk(clk), .rst(rst), .restart(ras_restart), .active(!dram_ras_n), .age(ras_age)
  );

  fpm_age_counter #(.W(AW), .INIT(0)) u_cas_age (
    .clk(clk), .rst(rst), .restart(cas_restart), .active(!dram_cas_n), .age(cas_age)
  );

  fpm_refresh_timer #(.INTERVAL(REF_INT)) u_refresh (
    .clk(clk), .rst(rst), .ack(ref_ack), .pend(ref_pend)
  );

  assign ras_ok    = (ras_age >= AW'(T_RAS));
  assign row_hit   = (req_row == row_q);
  assign req_ready = !ref_pend && ((state == S_IDLE) || (state == S_OPEN && row_hit));
  assign accept    = req_valid && req_ready;

  always_comb begin
    n_state     = state;
    n_row       = row_q;
    n_col       = col_q;
    n_wr        = wr_q;
    n_wdata     = wdata_q;
    n_ras_n     = dram_ras_n;
    n_cas_n     = dram_cas_n;
    n_we_n      = dram_we_n;
    n_oe_n      = dram_oe_n;
    n_addr      = dram_addr;
    n_dq_out    = dram_dq_out;
    n_dq_oe     = dram_dq_oe;
    n_rd_valid  = 1'b0;
    n_rd_data   = rd_data;
    t_load      = 1'b0;
    t_val       = '0;
    ras_restart = 1'b0;
    cas_restart = 1'b0;
    ref_ack     = 1'b0;
    case (state)
      S_IDLE: begin
        if (ref_pend) begin
          n_cas_n = 1'b0;
          n_state = S_RFC;
        end else if (req_valid) begin
          n_row       = req_row;
          n_col       = req_col;
          n_wr        = req_write;
          n_wdata     = req_wdata;
          n_ras_n     = 1'b0;
          n_addr      = MA_W'(req_row);
          ras_restart = 1'b1;
          t_load      = 1'b1;
          t_val       = TW'(T_RCD - 1);
          n_state     = S_RAS;
        end
      end
      S_RAS: begin
        if (t_done) begin
          n_addr   = MA_W'(col_q);
          n_we_n   = !wr_q;
          n_dq_oe  = wr_q;
          n_dq_out = wdata_q;
          n_state  = S_COL;
        end
      end
      S_COL: begin
        n_cas_n     = 1'b0;
        n_oe_n      = wr_q;
        cas_restart = 1'b1;
        t_load      = 1'b1;
        t_val       = TW'(T_CAS - 1);
        n_state     = S_CAS;
      end
      S_CAS: begin
        if (!wr_q && cas_age == AW'(T_ACC)) begin
          n_rd_valid = 1'b1;
          n_rd_data  = dram_dq_in;
        end
        if (t_done) begin
          n_cas_n = 1'b1;
          n_oe_n  = 1'b1;
          n_we_n  = 1'b1;
          n_dq_oe = 1'b0;
          t_load  = 1'b1;
          t_val   = TW'(T_CP - 1);
          n_state = S_CPRE;
        end
      end
      S_CPRE: begin
        if (t_done) n_state = S_OPEN;
      end
      S_OPEN: begin
        if (accept) begin
          n_col    = req_col;
          n_wr     = req_write;
          n_wdata  = req_wdata;
          n_addr   = MA_W'(req_col);
          n_we_n   = !req_write;
          n_dq_oe  = req_write;
          n_dq_out = req_wdata;
          n_state  = S_COL;
        end else if (ras_ok) begin
          n_ras_n = 1'b1;
          t_load  = 1'b1;
          t_val   = TW'(T_RP - 1);
          n_state = S_PRE;
        end
      end
      S_PRE: begin
        if (t_done) n_state = S_IDLE;
      end
      S_RFC: begin
        n_ras_n     = 1'b0;
        ras_restart = 1'b1;
        t_load      = 1'b1;
        t_val       = TW'(T_RAS - 1);
        n_state     = S_RFR;
      end
      S_RFR: begin
        if (t_done) begin
          n_ras_n = 1'b1;
          n_cas_n = 1'b1;
          ref_ack = 1'b1;
          t_load  = 1'b1;
          t_val   = TW'(T_RP - 1);
          n_state = S_PRE;
        end
      end
      default: n_state = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      row_q       <= '0;
      col_q       <= '0;
      wr_q        <= 1'b0;
      wdata_q     <= '0;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_addr   <= '0;
      dram_dq_out <= '0;
      dram_dq_oe  <= 1'b0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
    end else begin
      state       <= n_state;
      row_q       <= n_row;
      col_q       <= n_col;
      wr_q        <= n_wr;
      wdata_q     <= n_wdata;
      dram_ras_n  <= n_ras_n;
      dram_cas_n  <= n_cas_n;
      dram_we_n   <= n_we_n;
      dram_oe_n   <= n_oe_n;
      dram_addr   <= n_addr;
      dram_dq_out <= n_dq_out;
      dram_dq_oe  <= n_dq_oe;
      rd_valid    <= n_rd_valid;
      rd_data     <= n_rd_data;
    end
  end

  // Strobe high-time trackers for the width properties below.
  logic [AW-1:0] ras_hi_age, cas_hi_age;
  always_ff @(posedge clk) begin
    if (rst) begin
      ras_hi_age <= '1;
      cas_hi_age <= '1;
    end else begin
      if (!dram_ras_n)              ras_hi_age <= AW'(1);
      else if (ras_hi_age != '1)    ras_hi_age <= ras_hi_age + 1'b1;
      if (!dram_cas_n)              cas_hi_age <= AW'(1);
      else if (cas_hi_age != '1)    cas_hi_age <= cas_hi_age + 1'b1;
    end
  end

  // R4
  ras_active_min_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dram_ras_n) |-> $past(ras_age) >= AW'(T_RAS));

  // R5
  ras_precharge_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_ras_n) |-> $past(ras_hi_age) >= AW'(T_RP));

  // R6
  cas_precharge_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_cas_n) |-> $past(cas_hi_age) >= AW'(T_CP));

  // R7
  early_write_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(dram_cas_n) && !dram_we_n) |-> ($past(!dram_we_n) && dram_oe_n && dram_dq_oe));

  // R8
  read_oe_chk: assert property (@(posedge clk) disable iff (rst)
    !dram_oe_n |-> (dram_we_n && !dram_cas_n));

  // R9
  cbr_we_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(dram_cas_n) && dram_ras_n) |-> dram_we_n);

  // R11
  cas_width_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(dram_cas_n) && !dram_ras_n) |-> $past(cas_age) == AW'(T_CAS));
endmodule

// File: tb/fpm_dram_ctrl_tb.sv
module fpm_dram_ctrl_tb;
  localparam int T_RCD   = 2;
  localparam int T_RAS   = 6;
  localparam int T_RP    = 3;
  localparam int T_CAS   = 3;
  localparam int T_CP    = 2;
  localparam int T_ACC   = 2;
  localparam int REF_INT = 2000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [18:0] req_addr  = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rd_valid;
  logic [15:0] rd_data;
  logic [9:0]  dram_addr;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [15:0] dram_dq_out, dram_dq_in;

  always #10 clk = ~clk;

  fpm_dram_ctrl #(
    .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_CAS(T_CAS),
    .T_CP(T_CP), .T_ACC(T_ACC), .REF_INT(REF_INT)
  ) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dram_dq_in)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input logic [9:0] r, input logic [8:0] c);
    return (16'(r) * 16'd97 + 16'(c) * 16'd13) ^ 16'hA5C3;
  endfunction

  // Expected access stream
  logic [18:0] exp_addr [256];
  logic        exp_wr   [256];
  logic [15:0] exp_dat  [256];
  logic [18:0] rd_q     [256];
  int n_iss = 0, acc_i = 0, n_rd = 0, rd_i = 0;

  // Strobe-level memory model and monitor
  logic       prev_ras = 1'b1, prev_cas = 1'b1, prev_we = 1'b1;
  int         ras_lo = 0, ras_hi = 100, cas_lo = 0, cas_hi = 100;
  int         opens = 0, refs = 0;
  logic [9:0] lat_row = '0;
  logic [8:0] lat_col = '0;

  assign dram_dq_in = (!dram_ras_n && !dram_cas_n && !dram_oe_n && dram_we_n && cas_lo >= T_ACC)
                      ? pat(lat_row, lat_col) : 16'hDEAD;

  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (!dram_ras_n && prev_ras) begin
        chk(ras_hi >= T_RP, "R5 ras high width", ras_hi, T_RP);
        if (dram_cas_n) begin
          opens++;
          lat_row = dram_addr;
        end
        ras_lo = 1;
      end else if (!dram_ras_n) ras_lo++;
      if (dram_ras_n && !prev_ras) begin
        chk(ras_lo >= T_RAS, "R4 ras low width", ras_lo, T_RAS);
        ras_hi = 1;
      end else if (dram_ras_n) ras_hi++;

      if (!dram_cas_n && prev_cas) begin
        if (dram_ras_n) begin
          refs++;
          chk(dram_we_n && !req_ready, "R9 refresh we/ready", {dram_we_n, req_ready}, 2'b10);
        end else begin
          chk(cas_hi >= T_CP, "R6 cas high width", cas_hi, T_CP);
          lat_col = dram_addr[8:0];
          if (acc_i < n_iss) begin
            chk({lat_row, dram_addr} == {exp_addr[acc_i][18:9], 1'b0, exp_addr[acc_i][8:0]},
                "R1 row/col address", {lat_row, dram_addr},
                {exp_addr[acc_i][18:9], 1'b0, exp_addr[acc_i][8:0]});
            if (exp_wr[acc_i])
              chk(!prev_we && !dram_we_n && dram_oe_n && dram_dq_oe && dram_dq_out == exp_dat[acc_i],
                  "R7 early write", {prev_we, dram_we_n, dram_oe_n, dram_dq_oe, dram_dq_out},
                  {4'b0011, exp_dat[acc_i]});
            else
              chk(dram_we_n && !dram_oe_n, "R8 read strobes", {dram_we_n, dram_oe_n}, 2'b10);
          end else chk(0, "R1 unexpected access", acc_i, n_iss);
          acc_i++;
        end
        cas_lo = 1;
      end else if (!dram_cas_n) cas_lo++;
      if (dram_cas_n && !prev_cas) begin
        if (!dram_ras_n) chk(cas_lo == T_CAS, "R11 cas low width", cas_lo, T_CAS);
        cas_hi = 1;
      end else if (dram_cas_n) cas_hi++;

      if (rd_valid) begin
        if (rd_i < n_rd)
          chk(rd_data == pat(rd_q[rd_i][18:9], rd_q[rd_i][8:0]), "R8 read data", rd_data,
              pat(rd_q[rd_i][18:9], rd_q[rd_i][8:0]));
        else chk(0, "R8 extra rd_valid", rd_i, n_rd);
        rd_i++;
      end
      prev_ras = dram_ras_n;
      prev_cas = dram_cas_n;
      prev_we  = dram_we_n;
    end
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      report();
      $finish;
    end
  end

  task automatic issue(input logic wr, input logic [18:0] a, input logic [15:0] d);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    exp_addr[n_iss] = a;
    exp_wr[n_iss]   = wr;
    exp_dat[n_iss]  = d;
    n_iss++;
    if (!wr) begin
      rd_q[n_rd] = a;
      n_rd++;
    end
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Row openings during a block: expected count plus one per refresh in between.
  task automatic chk_opens(input string req, input int o0, input int r0, input int exp);
    int d_o, d_r;
    d_o = opens - o0;
    d_r = refs - r0;
    chk(d_o >= exp && d_o <= exp + d_r, req, d_o, exp);
  endtask

  initial begin
    int o0, r0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe, rd_valid, req_ready} == 7'b1111001,
        "R10 reset state", {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe, rd_valid, req_ready},
        7'b1111001);

    // Single write from idle
    issue(1'b1, {10'd5, 9'd0}, 16'h1357);
    idle(30);

    // R2: same-row write burst, then read burst
    o0 = opens; r0 = refs;
    for (int c = 0; c < 15; c++) issue(1'b1, {10'd5, 9'(c * 34)}, 16'(c * 1111));
    issue(1'b1, {10'd5, 9'd511}, 16'hFFFF);
    idle(30);
    chk_opens("R2 one row opening for write burst", o0, r0, 1);
    o0 = opens; r0 = refs;
    for (int c = 0; c < 15; c++) issue(1'b0, {10'd5, 9'(c * 34)}, 16'h0);
    issue(1'b0, {10'd5, 9'd511}, 16'h0);
    idle(30);
    chk_opens("R2 one row opening for read burst", o0, r0, 1);

    // R3: row misses
    o0 = opens; r0 = refs;
    issue(1'b0, {10'd7, 9'd3}, 16'h0);
    issue(1'b1, {10'd900, 9'd100}, 16'hBEEF);
    issue(1'b0, {10'd7, 9'd4}, 16'h0);
    issue(1'b0, {10'd1023, 9'd511}, 16'h0);
    idle(30);
    chk_opens("R3 row miss reopens", o0, r0, 4);
    chk(dram_ras_n == 1'b1, "R3 row closed when idle", dram_ras_n, 1);

    // Sweep of rows with mixed operations
    o0 = opens; r0 = refs;
    for (int r = 0; r < 16; r++) begin
      issue(1'b1, {10'(r * 68 + 3), 9'(r * 32)}, 16'(r * 4099));
      issue(1'b0, {10'(r * 68 + 3), 9'(r * 32)}, 16'h0);
      issue(1'b0, {10'(r * 68 + 3), 9'(511 - r)}, 16'h0);
      issue(1'b1, {10'(r * 68 + 3), 9'(r)}, 16'(r * 7 + 1));
    end
    idle(30);
    chk_opens("R3 one opening per swept row", o0, r0, 16);

    // R9: refresh appears while idle
    r0 = refs;
    idle(REF_INT + 100);
    chk(refs - r0 >= 1, "R9 refresh while idle", refs - r0, 1);
    chk(dram_ras_n && dram_cas_n, "R9 strobes released after refresh", {dram_ras_n, dram_cas_n}, 2'b11);

    chk(acc_i == n_iss, "R1 access count", acc_i, n_iss);
    chk(rd_i == n_rd, "R8 read return count", rd_i, n_rd);

    finished = 1;
    report();
    $finish;
  end
endmodule